// File: doc/BRIEF.md
# Decode-Stage Operand Forwarding and Hazard Unit

This block sits beside the decode stage of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back) whose register file is read in decode. Decode names two source registers. The unit compares each of them with the destination registers of the instructions now in execute, memory and write-back. For each operand it then picks the newest pending result, or the register-file value when nothing in flight writes that register. Forwarded values therefore arrive before the end of decode. The register file itself is updated only when write-back completes.

The same unit decides when the front of the pipe must wait. Two cases cause a wait. In the first, a load in execute targets a register that decode reads. The loaded word only exists after the memory stage, so one stall cycle is needed. In the second, the single shared memory port is wanted in the same cycle by a data access and by an instruction fetch. In both cases the unit raises a hold for the fetch and decode pipeline registers and requests a no-operation bubble into execute.

A small state machine with three states tracks the stall history. `ST_RUN` is the normal state. `ST_LOAD_HOLD` is the cycle after a load-use stall. `ST_PORT_HOLD` is the cycle after a port-conflict stall. A port conflict moves any state to `ST_PORT_HOLD`. If there is no port conflict, a load-use match moves `ST_RUN` or `ST_PORT_HOLD` to `ST_LOAD_HOLD`. Every other case returns to `ST_RUN`. In `ST_LOAD_HOLD` a load-use match is not signalled again, so a load-use stall lasts exactly one cycle.

Top module: `opfwd_unit`

## Requirements
- R1: Directly after reset, with no matching destinations and no port request, `hold_fd` and `bubble_ex` are 0 and each operand equals its register-file input.
- R2: The destination id 8 is the null id and never matches a source. With every destination null, both operands equal their register-file inputs, and a load with null destination causes no stall.
- R3: When the execute destination equals a source, that operand takes `ex_val`, even when memory and write-back also match.
- R4: When memory and write-back both match a source and execute does not, the operand takes `mem_val`.
- R5: When only write-back matches a source, the operand takes `wb_val`, not the register-file value.
- R6: Operands A and B are selected independently. Each follows only its own source id.
- R7: When `ex_is_load` is 1 and the non-null execute destination equals either source, `hold_fd` and `bubble_ex` are 1 in that same cycle. This applies in `ST_RUN` and `ST_PORT_HOLD`.
- R8: In the cycle after a load-use stall, a load-use match alone does not stall again. Two cycles after the stall it stalls again if the match is still present.
- R9: Whenever `fetch_req` and `mem_port_req` are both 1, `hold_fd` and `bubble_ex` are 1 in that cycle, for every cycle the conflict lasts.
- R10: `bubble_ex` always equals `hold_fd`. A match in execute by a non-load instruction never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dec_src_a | input | 4 | Decode source id for operand A |
| dec_src_b | input | 4 | Decode source id for operand B |
| rf_val_a | input | 32 | Register-file read value for A |
| rf_val_b | input | 32 | Register-file read value for B |
| ex_dst | input | 4 | Execute-stage destination id (8 = none) |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_val | input | 32 | Execute-stage ALU result |
| mem_dst | input | 4 | Memory-stage destination id |
| mem_val | input | 32 | Memory-stage result (loaded or passed on) |
| wb_dst | input | 4 | Write-back destination id |
| wb_val | input | 32 | Write-back result |
| fetch_req | input | 1 | Fetch wants the shared memory port |
| mem_port_req | input | 1 | Memory stage wants the shared port for data |
| opnd_a | output | 32 | Resolved operand A |
| opnd_b | output | 32 | Resolved operand B |
| hold_fd | output | 1 | Hold fetch and decode pipeline registers |
| bubble_ex | output | 1 | Inject a no-operation into execute |

## Verification
A wrong priority in the match chain shows up at once. It appears on `opnd_a` or `opnd_b` in the same cycle that two stages hold the same destination. Such a fault never lasts more than one cycle on its own. A state-machine fault shows up one cycle later. The clearest case is a load-use match that stays in place across consecutive cycles: the stall pattern must be 1, 0, 1. A state held too long, or not entered, bends that pattern on `hold_fd` within two cycles.

// File: rtl/opfwd_pkg.sv
package opfwd_pkg;

    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_WB  = 2'd1,
        SRC_MEM = 2'd2,
        SRC_EX  = 2'd3
    } fwd_sel_e;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_LOAD_HOLD = 2'd1,
        ST_PORT_HOLD = 2'd2
    } haz_state_e;

endpackage

// File: rtl/opfwd_match.sv
module opfwd_match
    import opfwd_pkg::*;
#(
    parameter int ID_W = 4,
    parameter logic [ID_W-1:0] NULL_ID = 4'd8
) (
    input  logic [ID_W-1:0] src,
    input  logic [ID_W-1:0] ex_dst,
    input  logic [ID_W-1:0] mem_dst,
    input  logic [ID_W-1:0] wb_dst,
    output fwd_sel_e        sel,
    output logic            ex_hit
);

    logic hit_ex, hit_mem, hit_wb;

    always_comb begin
        hit_ex  = (ex_dst  != NULL_ID) && (ex_dst  == src);
        hit_mem = (mem_dst != NULL_ID) && (mem_dst == src);
        hit_wb  = (wb_dst  != NULL_ID) && (wb_dst  == src);
    end

    // youngest producer wins
    always_comb begin
        if (hit_ex)       sel = SRC_EX;
        else if (hit_mem) sel = SRC_MEM;
        else if (hit_wb)  sel = SRC_WB;
        else              sel = SRC_RF;
    end

    assign ex_hit = hit_ex;

endmodule

// File: rtl/opfwd_mux.sv
module opfwd_mux
    import opfwd_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  fwd_sel_e          sel,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] ex_val,
    input  logic [DATA_W-1:0] mem_val,
    input  logic [DATA_W-1:0] wb_val,
    output logic [DATA_W-1:0] y
);

    always_comb begin
        unique case (sel)
            SRC_EX:  y = ex_val;
            SRC_MEM: y = mem_val;
            SRC_WB:  y = wb_val;
            SRC_RF:  y = rf_val;
            default: y = rf_val;
        endcase
    end

endmodule

// File: rtl/opfwd_hazard_fsm.sv
module opfwd_hazard_fsm
    import opfwd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load_hit,
    input  logic port_conflict,
    output logic hold,
    output logic bubble
);

    haz_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = ST_RUN;
        unique case (state_q)
            ST_RUN: begin
                if (port_conflict) state_d = ST_PORT_HOLD;
                else if (load_hit) state_d = ST_LOAD_HOLD;
                else               state_d = ST_RUN;
            end
            ST_LOAD_HOLD: begin
                if (port_conflict) state_d = ST_PORT_HOLD;
                else               state_d = ST_RUN;
            end
            ST_PORT_HOLD: begin
                if (port_conflict) state_d = ST_PORT_HOLD;
                else if (load_hit) state_d = ST_LOAD_HOLD;
                else               state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        hold = 1'b0;
        unique case (state_q)
            ST_RUN:       hold = port_conflict | load_hit;
            ST_LOAD_HOLD: hold = port_conflict;
            ST_PORT_HOLD: hold = port_conflict | load_hit;
            default:      hold = port_conflict;
        endcase
        bubble = hold;
    end

    // R9: a port conflict always stalls the front end
    a_r9_port_stall: assert property (@(posedge clk) disable iff (!rst_n)
        port_conflict |-> (hold && bubble));

    // R8: a load-only stall is never followed by another load-only stall
    a_r8_single_load_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !port_conflict) |=> (port_conflict || !hold));

    // R10: bubble tracks hold
    a_r10_bubble_eq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        bubble == hold);

endmodule

// File: rtl/opfwd_unit.sv
module opfwd_unit
    import opfwd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ID_W = 4,
    parameter logic [ID_W-1:0] NULL_ID = 4'd8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   dec_src_a,
    input  logic [ID_W-1:0]   dec_src_b,
    input  logic [DATA_W-1:0] rf_val_a,
    input  logic [DATA_W-1:0] rf_val_b,
    input  logic [ID_W-1:0]   ex_dst,
    input  logic              ex_is_load,
    input  logic [DATA_W-1:0] ex_val,
    input  logic [ID_W-1:0]   mem_dst,
    input  logic [DATA_W-1:0] mem_val,
    input  logic [ID_W-1:0]   wb_dst,
    input  logic [DATA_W-1:0] wb_val,
    input  logic              fetch_req,
    input  logic              mem_port_req,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b,
    output logic              hold_fd,
    output logic              bubble_ex
);

    localparam int N_OPND = 2;

    logic [ID_W-1:0]   src_arr [N_OPND];
    logic [DATA_W-1:0] rf_arr  [N_OPND];
    logic [DATA_W-1:0] opnd_arr[N_OPND];
    fwd_sel_e          sel_arr [N_OPND];
    logic [N_OPND-1:0] ex_hit_vec;

    logic load_hit;
    logic port_conflict;

    assign src_arr[0] = dec_src_a;
    assign src_arr[1] = dec_src_b;
    assign rf_arr[0]  = rf_val_a;
    assign rf_arr[1]  = rf_val_b;

    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_opnd
        opfwd_match #(
            .ID_W    (ID_W),
            .NULL_ID (NULL_ID)
        ) u_match (
            .src     (src_arr[gi]),
            .ex_dst  (ex_dst),
            .mem_dst (mem_dst),
            .wb_dst  (wb_dst),
            .sel     (sel_arr[gi]),
            .ex_hit  (ex_hit_vec[gi])
        );

        opfwd_mux #(
            .DATA_W (DATA_W)
        ) u_mux (
            .sel     (sel_arr[gi]),
            .rf_val  (rf_arr[gi]),
            .ex_val  (ex_val),
            .mem_val (mem_val),
            .wb_val  (wb_val),
            .y       (opnd_arr[gi])
        );
    end

    assign opnd_a = opnd_arr[0];
    assign opnd_b = opnd_arr[1];

    assign load_hit      = ex_is_load && (|ex_hit_vec);
    assign port_conflict = fetch_req && mem_port_req;

    opfwd_hazard_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_hit      (load_hit),
        .port_conflict (port_conflict),
        .hold          (hold_fd),
        .bubble        (bubble_ex)
    );

    // R3: execute result wins for operand A whenever it matches
    a_r3_ex_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst != NULL_ID && ex_dst == dec_src_a) |-> (opnd_a == ex_val));

    // R2: null destinations never forward
    a_r2_null_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_dst == NULL_ID && mem_dst == NULL_ID && wb_dst == NULL_ID)
        |-> (opnd_a == rf_val_a && opnd_b == rf_val_b && !(hold_fd && !port_conflict)));

    // R7: load-use match stalls unless in the hold cycle right after one
    a_r7_load_use: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load && ex_dst != NULL_ID && (ex_dst == dec_src_a || ex_dst == dec_src_b)
         && !hold_fd) |-> $past(hold_fd));

    // R10: non-load execute match with no port conflict never stalls
    a_r10_no_stall_alu: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_is_load && !port_conflict) |-> !hold_fd);

endmodule

// File: tb/opfwd_unit_bench.sv
module opfwd_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  dec_src_a, dec_src_b, ex_dst, mem_dst, wb_dst;
    logic [31:0] rf_val_a, rf_val_b, ex_val, mem_val, wb_val;
    logic        ex_is_load, fetch_req, mem_port_req;
    logic [31:0] opnd_a, opnd_b;
    logic        hold_fd, bubble_ex;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;
    bit  m_lh  = 1'b0;
    bit  m_lh_n = 1'b0;

    always #5 clk = ~clk;

    opfwd_unit u_opfwd_unit (
        .clk(clk), .rst_n(rst_n),
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
        .ex_dst(ex_dst), .ex_is_load(ex_is_load), .ex_val(ex_val),
        .mem_dst(mem_dst), .mem_val(mem_val),
        .wb_dst(wb_dst), .wb_val(wb_val),
        .fetch_req(fetch_req), .mem_port_req(mem_port_req),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .hold_fd(hold_fd), .bubble_ex(bubble_ex)
    );

    function automatic bit live_hit(input logic [3:0] d, input logic [3:0] s);
        return (d != 4'd8) && (d == s);
    endfunction

    function automatic logic [31:0] exp_opnd(input logic [3:0] s, input logic [31:0] rf);
        if (live_hit(ex_dst, s))  return ex_val;
        if (live_hit(mem_dst, s)) return mem_val;
        if (live_hit(wb_dst, s))  return wb_val;
        return rf;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // compare all outputs against the model, prepare next model state
    task automatic check_all(input string req);
        bit port, luse, exp_hold;
        #2;
        port = fetch_req && mem_port_req;
        luse = ex_is_load && (live_hit(ex_dst, dec_src_a) || live_hit(ex_dst, dec_src_b));
        exp_hold = port || (luse && !m_lh);
        chk(req, "opnd_a", opnd_a, exp_opnd(dec_src_a, rf_val_a));
        chk(req, "opnd_b", opnd_b, exp_opnd(dec_src_b, rf_val_b));
        chk(req, "hold_fd", {31'd0, hold_fd}, {31'd0, exp_hold});
        chk("R10", "bubble_ex", {31'd0, bubble_ex}, {31'd0, exp_hold});
        m_lh_n = !port && luse && !m_lh;
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst_n) m_lh = m_lh_n;
        @(negedge clk);
    endtask

    task automatic quiet();
        dec_src_a = 4'd1; dec_src_b = 4'd2;
        rf_val_a = 32'hA0A0_0001; rf_val_b = 32'hB0B0_0002;
        ex_dst = 4'd8; mem_dst = 4'd8; wb_dst = 4'd8;
        ex_val = 32'hEEEE_0000; mem_val = 32'h3333_0000; wb_val = 32'h7777_0000;
        ex_is_load = 1'b0; fetch_req = 1'b1; mem_port_req = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0BAD_F00D));
        quiet();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_lh = 1'b0;
        // R1: reset state
        check_all("R1"); tick();

        // R3: all stages match A
        quiet(); dec_src_a = 4'd3; ex_dst = 4'd3; mem_dst = 4'd3; wb_dst = 4'd3;
        check_all("R3"); tick();
        // R4: memory over write-back
        quiet(); dec_src_a = 4'd5; mem_dst = 4'd5; wb_dst = 4'd5; ex_dst = 4'd6;
        check_all("R4"); tick();
        // R5: write-back only
        quiet(); dec_src_b = 4'd7; wb_dst = 4'd7;
        check_all("R5"); tick();
        // R2: null ids everywhere, including a null-target load
        quiet(); dec_src_a = 4'd8; dec_src_b = 4'd8; ex_is_load = 1'b1;
        check_all("R2"); tick();
        // R6: independent selection
        quiet(); dec_src_a = 4'd4; dec_src_b = 4'd0; wb_dst = 4'd4; mem_dst = 4'd0;
        check_all("R6"); tick();
        // R7 then R8: load-use match held for three cycles -> 1,0,1
        quiet(); dec_src_b = 4'd6; ex_dst = 4'd6; ex_is_load = 1'b1;
        check_all("R7"); tick();
        check_all("R8"); tick();
        check_all("R8"); tick();
        quiet(); check_all("R8"); tick();
        // R9: port conflict lasting two cycles, with a load-use match behind it
        quiet(); mem_port_req = 1'b1;
        check_all("R9"); tick();
        dec_src_a = 4'd2; ex_dst = 4'd2; ex_is_load = 1'b1;
        check_all("R9"); tick();
        mem_port_req = 1'b0;
        check_all("R7"); tick();
        // R10: ALU match never stalls
        quiet(); dec_src_a = 4'd2; ex_dst = 4'd2;
        check_all("R10"); tick();

        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            dec_src_a    = 4'($urandom_range(0, 8));
            dec_src_b    = 4'($urandom_range(0, 8));
            ex_dst       = 4'($urandom_range(0, 8));
            mem_dst      = 4'($urandom_range(0, 8));
            wb_dst       = 4'($urandom_range(0, 8));
            rf_val_a     = $urandom; rf_val_b = $urandom;
            ex_val       = $urandom; mem_val  = $urandom; wb_val = $urandom;
            ex_is_load   = ($urandom_range(0, 2) == 0);
            fetch_req    = ($urandom_range(0, 4) != 0);
            mem_port_req = ($urandom_range(0, 3) == 0);
            check_all("R6");
            tick();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule